// File: doc/BRIEF.md
# Array Element Copy Sequencer

This block copies one word from a source single-port synchronous SRAM to a destination single-port synchronous SRAM. The word belongs to a two-dimensional array that is stored row by row. Each row is one particle, and each column is one dimension. An outside controller supplies a particle number and a dimension number, both counted from one, together with the row length (the number of dimensions). It then pulses `start`. The block converts the pair into a linear word address. It reads the source at that address and waits one cycle for the read data to come back. It then writes that word to the same address in the destination.

Both memories use active-low chip enables. On both, a low write enable selects a write and a high write enable selects a read. The block releases both memories after the write. It raises `done` for one cycle and returns to idle, ready for the next request. `busy` marks the whole transfer, and while it is high any new request is dropped.

Top module: `sram_elem_copier`

## Requirements
- R1: The transfer address is ((particle − 1) × dimensions + (dimension − 1)), taken modulo 2^ADDR_W. The indices are sampled in the clock cycle where `start` is accepted.
- R2: In the cycle after an accepted `start`, `src_cen_n` is low, `src_wen_n` is high and `src_addr` carries the transfer address. This lasts for exactly one cycle.
- R3: The read cycle is followed by exactly one wait cycle in which both chip enables are high. Neither memory is ever enabled in the same cycle as the other.
- R4: The wait cycle is followed by one write cycle. In it, `dst_cen_n` is low, `dst_wen_n` is low, `dst_addr` equals the transfer address, and `dst_wdata` equals the source word stored at that address.
- R5: In the cycle after the write, `done` is high for exactly one cycle, with both chip enables high and `dst_wen_n` high. The block is idle in the cycle after that.
- R6: `busy` is high from the read cycle through the `done` cycle, and low when idle.
- R7: A `start` that arrives while `busy` is high has no effect. The address in use is kept, and no extra memory access is made.
- R8: While reset is held and after it is released, the block is idle: both chip enables are high, both write enables are high, and `busy` and `done` are low.
- R9: `src_wen_n` stays high at all times, so the source is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request pulse, accepted only when idle |
| part_idx | input | IDX_W | Particle number, counted from 1 |
| dim_idx | input | IDX_W | Dimension number, counted from 1 |
| num_dims | input | IDX_W | Number of dimensions per particle (row length) |
| busy | output | 1 | High while a transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_cen_n | output | 1 | Source chip enable, active low |
| src_wen_n | output | 1 | Source write enable (low = write, high = read) |
| src_addr | output | ADDR_W | Source address |
| src_rdata | input | DATA_W | Source read data, valid one cycle after the read |
| dst_cen_n | output | 1 | Destination chip enable, active low |
| dst_wen_n | output | 1 | Destination write enable (low = write) |
| dst_addr | output | ADDR_W | Destination address |
| dst_wdata | output | DATA_W | Destination write data |

## Verification
The bench builds the block with its defaults: 8-bit indices, an 8-bit address and 16-bit words. With these values, a 256-word source model can hold a distinct pattern at every address, so a word taken from the wrong address or in the wrong cycle shows up at once. The 8-bit indices also allow a product that lands exactly on the last address (16 × 16). Requests are issued back to back and during busy, which exercises the one-cycle enable windows and the rule that a request made while busy is dropped.

// File: rtl/copy_pkg.sv
package copy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } copy_state_e;
endpackage

// File: rtl/copy_rst_sync.sv
module copy_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/copy_addr_calc.sv
module copy_addr_calc #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic [IDX_W-1:0]  part_idx,
  input  logic [IDX_W-1:0]  dim_idx,
  input  logic [IDX_W-1:0]  num_dims,
  output logic [ADDR_W-1:0] lin_addr
);
  localparam int PROD_W = 2 * IDX_W;

  logic [PROD_W-1:0] row_base;
  logic [PROD_W-1:0] col_off;
  logic [PROD_W-1:0] full_sum;

  always_comb begin
    row_base = PROD_W'(part_idx - 1'b1) * PROD_W'(num_dims);
    col_off  = PROD_W'(dim_idx - 1'b1);
    full_sum = row_base + col_off;
    lin_addr = ADDR_W'(full_sum);
  end
endmodule

// File: rtl/copy_seq.sv
module copy_seq
  import copy_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] rdata,
  output copy_state_e       state_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  copy_state_e state_d;
  logic        addr_en;
  logic        data_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign addr_en = (state_q == ST_IDLE) && start;
  assign data_en = (state_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= rdata;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(addr_q)) else $error("addr changed while busy"); // R7
endmodule

// File: rtl/sram_elem_copier.sv
module sram_elem_copier
  import copy_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  part_idx,
  input  logic [IDX_W-1:0]  dim_idx,
  input  logic [IDX_W-1:0]  num_dims,
  output logic              busy,
  output logic              done,
  output logic              src_cen_n,
  output logic              src_wen_n,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_rdata,
  output logic              dst_cen_n,
  output logic              dst_wen_n,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [DATA_W-1:0] dst_wdata
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] calc_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  copy_state_e       state_q;

  copy_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  copy_addr_calc #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_addr_calc (
    .part_idx (part_idx),
    .dim_idx  (dim_idx),
    .num_dims (num_dims),
    .lin_addr (calc_addr)
  );

  copy_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .addr_in (calc_addr),
    .rdata   (src_rdata),
    .state_q (state_q),
    .addr_q  (addr_q),
    .data_q  (data_q)
  );

  always_comb begin
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_DONE);
    src_cen_n = !(state_q == ST_READ);
    src_wen_n = 1'b1;
    src_addr  = addr_q;
    dst_cen_n = !(state_q == ST_WRITE);
    dst_wen_n = !(state_q == ST_WRITE);
    dst_addr  = addr_q;
    dst_wdata = data_q;
  end

  AST_READ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start && !busy |=> !src_cen_n && src_wen_n) else $error("no read after start"); // R2
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !src_cen_n |=> src_cen_n) else $error("read longer than one cycle"); // R2
  AST_WAIT_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dst_cen_n |-> $past(src_cen_n) && $past(dst_cen_n) && !$past(src_cen_n, 2)) else $error("write not two cycles after read"); // R3
  AST_NO_DUAL_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(!src_cen_n && !dst_cen_n)) else $error("both memories enabled"); // R3
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(!dst_cen_n) && dst_cen_n && src_cen_n && dst_wen_n) else $error("done not after write"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done && !busy) else $error("done longer than one cycle"); // R5
endmodule

// File: tb/test_sram_elem_copier.sv
module test_sram_elem_copier;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [IDX_W-1:0]  part_idx = '0;
  logic [IDX_W-1:0]  dim_idx = '0;
  logic [IDX_W-1:0]  num_dims = '0;
  logic              busy, done;
  logic              src_cen_n, src_wen_n, dst_cen_n, dst_wen_n;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [DATA_W-1:0] src_rdata, dst_wdata;

  logic [DATA_W-1:0] src_mem [DEPTH];
  logic [DATA_W-1:0] dst_mem [DEPTH];

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int ref_st   = 0;   // 0 idle, 1 read, 2 wait, 3 write, 4 done
  int ref_addr = 0;

  always #2 clk = ~clk;

  sram_elem_copier #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sram_elem_copier (
    .clk(clk), .rst_n(rst_n), .start(start), .part_idx(part_idx), .dim_idx(dim_idx),
    .num_dims(num_dims), .busy(busy), .done(done), .src_cen_n(src_cen_n),
    .src_wen_n(src_wen_n), .src_addr(src_addr), .src_rdata(src_rdata),
    .dst_cen_n(dst_cen_n), .dst_wen_n(dst_wen_n), .dst_addr(dst_addr), .dst_wdata(dst_wdata)
  );

  function automatic logic [DATA_W-1:0] pattern(int a);
    return DATA_W'(a * 37 + 'h1234);
  endfunction

  function automatic int lin(int p, int d, int n);
    return ((p - 1) * n + (d - 1)) % DEPTH;
  endfunction

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      src_mem[a] = pattern(a);
      dst_mem[a] = 16'hDEAD;
    end
    src_rdata = '0;
  end

  // memory models
  always @(posedge clk) begin
    if (!src_cen_n) begin
      if (src_wen_n) src_rdata <= src_mem[src_addr];
      else           src_mem[src_addr] <= 16'h0BAD;
    end
    if (!dst_cen_n && !dst_wen_n) dst_mem[dst_addr] <= dst_wdata;
  end

  // reference model
  always @(posedge clk) begin
    if (!rst_n) ref_st <= 0;
    else begin
      case (ref_st)
        0: if (start) begin
             ref_st   <= 1;
             ref_addr <= lin(int'(part_idx), int'(dim_idx), int'(num_dims));
           end
        4: ref_st <= 0;
        default: ref_st <= ref_st + 1;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    chk("R8/R5 src_cen_n", int'(src_cen_n), (ref_st == 1) ? 0 : 1);
    chk("R9 src_wen_n", int'(src_wen_n), 1);
    chk("R4 dst_cen_n", int'(dst_cen_n), (ref_st == 3) ? 0 : 1);
    chk("R4 dst_wen_n", int'(dst_wen_n), (ref_st == 3) ? 0 : 1);
    chk("R6 busy", int'(busy), (ref_st != 0) ? 1 : 0);
    chk("R5 done", int'(done), (ref_st == 4) ? 1 : 0);
    if (ref_st == 1) chk("R1 R2 src_addr", int'(src_addr), ref_addr);
    if (ref_st == 3) begin
      chk("R1 R4 dst_addr", int'(dst_addr), ref_addr);
      chk("R4 dst_wdata", int'(dst_wdata), int'(pattern(ref_addr)));
    end
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic request(int p, int d, int n);
    @(negedge clk);
    part_idx = IDX_W'(p);
    dim_idx  = IDX_W'(d);
    num_dims = IDX_W'(n);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic copy_and_check(int p, int d, int n);
    int a;
    a = lin(p, d, n);
    request(p, d, n);
    repeat (5) @(negedge clk);
    chk("R4 dst_mem content", int'(dst_mem[a]), int'(pattern(a)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", int'(busy), 0);
    chk("R8 dst_wen_n in reset", int'(dst_wen_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    copy_and_check(1, 1, 4);      // address 0
    copy_and_check(3, 2, 4);      // address 9
    copy_and_check(5, 4, 5);      // address 23
    copy_and_check(1, 5, 8);      // address 4
    copy_and_check(16, 16, 16);   // address 255, top of range

    // R7: start during busy with other indices must be dropped
    request(2, 2, 4);             // address 5
    part_idx = 8'd7; dim_idx = 8'd3; num_dims = 8'd10;  // address 62
    start = 1'b1;
    repeat (3) @(negedge clk);    // covers wait, write, done
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 dst_mem[62] untouched", int'(dst_mem[62]), 16'hDEAD);
    chk("R4 dst_mem[5]", int'(dst_mem[5]), int'(pattern(5)));

    // back-to-back requests, the second issued in the first idle cycle
    request(2, 3, 6);             // address 8
    repeat (3) @(negedge clk);
    copy_and_check(4, 1, 6);      // address 18
    chk("R4 dst_mem[8]", int'(dst_mem[8]), int'(pattern(8)));

    // R9: source contents unchanged
    chk("R9 src_mem[9] intact", int'(src_mem[9]), int'(pattern(9)));

    // reset in the middle of a transfer returns to idle
    request(6, 1, 3);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 busy after async reset", int'(busy), 0);
    chk("R8 src_cen_n after async reset", int'(src_cen_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    copy_and_check(2, 1, 3);      // address 3

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule